// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM of 131,072 words by 8 bits. The host presents a request with a read/write flag, a 17-bit word address and a byte of write data. The controller accepts it when its ready output is high. It then drives the memory's active-low chip-select, output-enable and write-strobe lines, the address bus and a split data path: byte out, a drive-enable for the external tristate pad, and byte in. Each timing phase lasts a whole number of clock cycles, set by a parameter. The designer chooses these counts so that they meet the memory's minimum pulse, setup and access times at the chosen clock.

A single finite-state machine sequences every access. It has seven states. ST_IDLE keeps the memory deselected. ST_WR_SETUP presents the address with the write strobe still high. ST_WR_PULSE lowers the write strobe and drives the byte. ST_WR_HOLD raises the write strobe while the byte and address stay put. ST_RD_ACCESS holds chip-select and output-enable low until the data is valid. ST_RD_DONE returns the captured byte with a one-cycle valid pulse. ST_RD_TURN keeps the bus quiet before the next request.

The transitions are as follows. IDLE goes to WR_SETUP or RD_ACCESS when a request is accepted. WR_SETUP goes to WR_PULSE and WR_PULSE goes to WR_HOLD, each when its phase counter expires. WR_HOLD goes to IDLE after one cycle. RD_ACCESS goes to RD_DONE when its counter expires, capturing the input byte on that same edge. RD_DONE goes to RD_TURN after one cycle, and RD_TURN goes to IDLE when its counter expires.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted, chip-select, output-enable and write strobe are all high (1), drive-enable is low, rsp_valid is low and req_ready is high.
- R2: Whenever no access is in progress, chip-select is high (1), output-enable and write strobe are high, and the data path is not driven.
- R3: A write keeps chip-select low and output-enable high. It holds the write strobe high for SETUP_CYC cycles, then low for WPULSE_CYC cycles, then high for one final cycle. The address is stable throughout.
- R4: The controller drives the data bus only while the write strobe is low and for the one cycle after it rises. The driven byte does not change over that whole window.
- R5: A read holds chip-select and output-enable low with the write strobe high for exactly ACCESS_CYC cycles, with a stable address.
- R6: The byte on mem_dq_in in the last read-access cycle is returned on rsp_rdata during a one-cycle rsp_valid pulse. That pulse falls in the cycle right after the access, with all strobes already high.
- R7: After every read, at least TURN_CYC further cycles pass with output-enable high and the bus undriven before the next request is accepted.
- R8: req_ready is high only in the idle state. A request is taken on a clock edge where req_valid and req_ready are both high. Address and write data are latched then, and later changes on req_addr or req_wdata have no effect on that access.
- R9: Output-enable is never low in a cycle where the controller drives the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request will be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 8 | Read byte |
| mem_ce_n | output | 1 | Memory chip-select, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Byte toward the pad |
| mem_dq_oe | output | 1 | Pad drive-enable, 1 = drive |
| mem_dq_in | input | 8 | Byte from the pad |

## Verification
The bound checker watches every cycle for bus contention with output-enable low, for drive outside the write-strobe window and its hold cycle, and for address or byte movement while the strobe is low or rising. It also checks that the strobes stay consistent with chip-select, that the valid pulse lasts a single cycle, and that the turnaround gap comes before any drive that follows a read. The bench's scenarios are what show the rest. Exact phase lengths and acceptance latency come from comparison against the cycle-level reference. Correct read data under the access delay comes from the memory model, which returns a poison byte until ACCESS_CYC cycles have passed. The model also checks that later changes on the request inputs are ignored and that back-to-back read/write orderings work.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS,
        ST_RD_DONE,
        ST_RD_TURN
    } ctl_state_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STROBE_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/sram_req_latch.sv
`timescale 1ns/1ps
module sram_req_latch #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (capture) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 1,
    parameter int WPULSE_CYC = 2,
    parameter int ACCESS_CYC = 3,
    parameter int TURN_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int MAX_CYC = max_of4(SETUP_CYC, WPULSE_CYC, ACCESS_CYC, TURN_CYC);
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] WPULSE_LD = CNT_W'(WPULSE_CYC - 1);
    localparam logic [CNT_W-1:0] ACCESS_LD = CNT_W'(ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LD   = CNT_W'(TURN_CYC - 1);

    ctl_state_t       state, state_nxt;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             accept;
    logic             capture;
    strobe_t          strb;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next state and phase-timer control
    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        accept    = 1'b0;
        capture   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_nxt = ST_WR_SETUP;
                        tmr_val   = SETUP_LD;
                    end else begin
                        state_nxt = ST_RD_ACCESS;
                        tmr_val   = ACCESS_LD;
                    end
                end
            end
            ST_WR_SETUP: begin
                if (tmr_expired) begin
                    state_nxt = ST_WR_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = WPULSE_LD;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_nxt = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                state_nxt = ST_IDLE;
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) begin
                    capture   = 1'b1;
                    state_nxt = ST_RD_DONE;
                end
            end
            ST_RD_DONE: begin
                state_nxt = ST_RD_TURN;
                tmr_load  = 1'b1;
                tmr_val   = TURN_LD;
            end
            ST_RD_TURN: begin
                if (tmr_expired) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    // strobe decode from state
    always_comb begin
        strb = STROBE_QUIET;
        unique case (state)
            ST_IDLE:      strb = STROBE_QUIET;
            ST_WR_SETUP:  strb = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
            ST_WR_PULSE:  strb = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
            ST_WR_HOLD:   strb = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
            ST_RD_ACCESS: strb = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
            ST_RD_DONE:   strb = STROBE_QUIET;
            ST_RD_TURN:   strb = STROBE_QUIET;
            default:      strb = STROBE_QUIET;
        endcase
    end

    assign mem_ce_n  = strb.ce_n;
    assign mem_oe_n  = strb.oe_n;
    assign mem_we_n  = strb.we_n;
    assign mem_dq_oe = strb.dq_oe;
    assign req_ready = (state == ST_IDLE);
    assign rsp_valid = (state == ST_RD_DONE);

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_req_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_out)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (mem_dq_in),
        .dout    (rsp_rdata)
    );
endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int TURN_CYC = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    logic [7:0] oe_hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_hi_run <= 8'hFF;
        end else if (!mem_oe_n) begin
            oe_hi_run <= 8'h00;
        end else if (oe_hi_run != 8'hFF) begin
            oe_hi_run <= oe_hi_run + 8'h01;
        end
    end

    // R9
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R2
    quiet_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

    // R3
    write_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> ($stable(mem_addr) && !mem_ce_n && mem_oe_n));

    // R4
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n || $rose(mem_we_n)));

    // R4
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)));

    // R5
    read_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n && !mem_dq_oe));

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_ce_n && mem_oe_n && mem_we_n));

    // R7
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (int'(oe_hi_run) > TURN_CYC));

    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !rsp_valid));
endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TURN_CYC (TURN_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int S  = 1;
    localparam int P  = 2;
    localparam int A  = 3;
    localparam int T  = 1;

    logic          clk;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic          req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          mem_ce_n, mem_oe_n, mem_we_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic          mem_dq_oe;
    logic [DW-1:0] mem_dq_in;

    sram_ctl #(
        .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .WPULSE_CYC(P),
        .ACCESS_CYC(A), .TURN_CYC(T)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural memory with strobe timing checks
    logic [DW-1:0] bmem [int];
    int            rd_age = 0;
    int            we_low = 0;
    logic          prev_we_n = 1'b1;
    logic [DW-1:0] we_data;

    initial mem_dq_in = 8'hEE;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(mem_dq_oe && !mem_oe_n), "R9 drive with output-enable low", int'(mem_oe_n), 1);
            if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_age++;
            else rd_age = 0;
            if (rd_age >= A)
                mem_dq_in = bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 8'h00;
            else
                mem_dq_in = 8'hEE;
            if (!mem_we_n) begin
                if (prev_we_n) begin
                    we_low  = 1;
                    we_data = mem_dq_out;
                end else begin
                    we_low++;
                end
                chk(mem_dq_oe && !mem_ce_n && mem_oe_n, "R3 strobes during write pulse",
                    int'({mem_dq_oe, mem_ce_n, mem_oe_n}), 3'b101);
                chk(mem_dq_out == we_data, "R4 byte stable in pulse", int'(mem_dq_out), int'(we_data));
            end else if (!prev_we_n) begin
                chk(we_low >= P, "R3 write pulse width", we_low, P);
                chk(mem_dq_oe && mem_dq_out == we_data, "R4 hold after strobe rise",
                    int'(mem_dq_out), int'(we_data));
                bmem[int'(mem_addr)] = mem_dq_out;
            end
            prev_we_n = mem_we_n;
        end
    end

    // cycle-level reference of the host-visible and strobe behaviour
    int            ref_busy = 0;
    bit            ref_rd   = 0;
    logic [AW-1:0] ref_addr = '0;
    logic [DW-1:0] ref_wdata = '0;
    logic [DW-1:0] ref_exp  = '0;
    logic [DW-1:0] ref_mem [int];

    always @(posedge clk) begin
        if (!rst_n) begin
            ref_busy = 0;
        end else if (ref_busy == 0) begin
            if (req_valid) begin
                ref_rd   = !req_write;
                ref_addr = req_addr;
                if (req_write) begin
                    ref_busy  = S + P + 1;
                    ref_wdata = req_wdata;
                    ref_mem[int'(req_addr)] = req_wdata;
                end else begin
                    ref_busy = A + 1 + T;
                    ref_exp  = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 8'h00;
                end
            end
        end else begin
            ref_busy--;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit e_ce, e_oe, e_we, e_drv, e_val;
            e_ce  = ref_busy > 0 && (!ref_rd || ref_busy > 1 + T);
            e_oe  = ref_rd && ref_busy > 1 + T;
            e_we  = !ref_rd && ref_busy >= 2 && ref_busy <= P + 1;
            e_drv = !ref_rd && ref_busy >= 1 && ref_busy <= P + 1;
            e_val = ref_rd && ref_busy == 1 + T;
            chk(req_ready == (ref_busy == 0), "R8 ready only when idle", int'(req_ready), int'(ref_busy == 0));
            chk(!mem_ce_n == e_ce, ref_busy == 0 ? "R2 chip-select idle" : (ref_rd ? "R5 chip-select read" : "R3 chip-select write"),
                int'(mem_ce_n), int'(!e_ce));
            chk(!mem_oe_n == e_oe, ref_rd ? "R5 output-enable read" : "R3 output-enable write", int'(mem_oe_n), int'(!e_oe));
            chk(!mem_we_n == e_we, "R3 write strobe phase", int'(mem_we_n), int'(!e_we));
            chk(mem_dq_oe == e_drv, "R4 drive window", int'(mem_dq_oe), int'(e_drv));
            chk(rsp_valid == e_val, ref_rd && ref_busy <= T ? "R7 turnaround" : "R6 valid pulse", int'(rsp_valid), int'(e_val));
            if (e_ce) chk(mem_addr == ref_addr, "R8 latched address", int'(mem_addr), int'(ref_addr));
            if (e_drv) chk(mem_dq_out == ref_wdata, "R8 latched write byte", int'(mem_dq_out), int'(ref_wdata));
            if (e_val) chk(rsp_rdata == ref_exp, "R6 read data", int'(rsp_rdata), int'(ref_exp));
        end
    end

    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        do @(negedge clk); while (!req_ready);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~a;
        req_wdata = ~d;
    endtask

    initial begin
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        rst_n     = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes in reset",
            int'({mem_ce_n, mem_oe_n, mem_we_n}), 3'b111);
        chk(!mem_dq_oe && !rsp_valid, "R1 drive and valid in reset",
            int'({mem_dq_oe, rsp_valid}), 0);
        chk(req_ready, "R1 ready in reset", int'(req_ready), 1);
        rst_n = 1'b1;

        issue(1'b1, 17'h00000, 8'hA5);
        issue(1'b1, 17'h1FFFF, 8'h5A);
        issue(1'b1, 17'h00012, 8'hFF);
        issue(1'b1, 17'h00013, 8'h00);
        issue(1'b0, 17'h00000, 8'h11);
        issue(1'b0, 17'h1FFFF, 8'h22);
        issue(1'b0, 17'h00012, 8'h33);
        issue(1'b0, 17'h00013, 8'h44);
        // write then read back-to-back, read then write
        issue(1'b1, 17'h00000, 8'h3C);
        issue(1'b0, 17'h00000, 8'h00);
        issue(1'b0, 17'h1FFFF, 8'h00);
        issue(1'b1, 17'h1FFFF, 8'hC3);
        issue(1'b0, 17'h1FFFF, 8'h00);
        for (int i = 1; i <= 24; i++) begin
            issue(1'b1, AW'((i * 4099) % 131072), DW'(i * 37 + 1));
        end
        for (int i = 24; i >= 1; i--) begin
            issue(1'b0, AW'((i * 4099) % 131072), 8'h00);
        end
        repeat (12) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule